// File: doc/BRIEF.md
# Combined-Event Performance Counter

This block is one 64-bit hardware performance counter together with its own 64-bit event selector. On every clock the surrounding core presents a vector of small per-event increment values, one slice per event source. The selector names four of those sources by 10-bit index. It combines them pairwise and then once more through a two-level tree whose operators are each chosen by a 5-bit field. The tree's result is added to the counter.

Counting can be stopped globally by a count-inhibit input, or per privilege mode by five inhibit bits held in the selector. When an addition carries out of the counter, an overflow flag in the selector's top bit is raised. If that flag was clear before the carry, the block also emits a single-cycle overflow request.

Software reaches the selector and the counter through plain write-enable and write-data ports and reads both back continuously. Address decoding, the routing of the overflow request and the generation of events all sit outside the block.

Top module: `pmc_combo_counter`

## Requirements
- R1: While reset is asserted and right after it, the selector reads zero, the counter reads zero and the overflow request is low.
- R2: Event indices sit in selector bits 9:0 (slot 0), 19:10 (slot 1), 29:20 (slot 2) and 39:30 (slot 3). Index k in the range 1..NUM_EVENTS selects the increment slice `ev_inc[(k-1)*6 +: 6]`. Index 0, and any index above NUM_EVENTS, contributes zero.
- R3: The operator fields are bits 44:40 (first pair), 49:45 (second pair) and 54:50 (final stage). The codes are 5'b00000 OR, 5'b00001 AND, 5'b00010 XOR and 5'b00100 ADD. Every other code behaves as OR.
- R4: The first-pair result combines slots 0 and 1. The second-pair result combines slots 2 and 3. The final stage combines those two results. ADD widens its result by one bit at each stage, so a sum never truncates. The final value is added to the counter in the next clock edge.
- R5: Privilege mode codes are 3'b011 machine, 3'b001 supervisor, 3'b000 user, 3'b101 virtual supervisor and 3'b100 virtual user. Their inhibit bits are 62, 61, 60, 59 and 58 respectively. A set bit for the current mode stops counting. Other mode codes are never inhibited.
- R6: While `count_inhibit` is high, the counter does not accumulate.
- R7: A carry out of the counter during accumulation sets selector bit 63. The overflow request is high for exactly the one cycle in which the wrapped counter value first appears, and only if bit 63 was clear before the carry.
- R8: Bit 63 stays set across further accumulation and further wraps. Only a selector write changes it.
- R9: A counter write loads the written value at the next edge and suppresses accumulation in that cycle.
- R10: A selector write loads all 64 bits at the next edge and suppresses accumulation, and therefore any overflow, in that cycle. The new selector governs counting from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_inc | input | NUM_EVENTS*EV_W | Per-event increment values, event k in slice k-1 |
| priv_mode | input | 3 | Current privilege mode code |
| count_inhibit | input | 1 | Global stop for this counter |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_data | input | 64 | Selector write value |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | CNT_W | Counter write value |
| sel_rd | output | 64 | Current selector, overflow flag in bit 63 |
| cnt_rd | output | CNT_W | Current counter value |
| ovf_irq | output | 1 | One-cycle overflow request |

## Verification
Software writes and accumulation can fall in the same cycle. The sharpest case is a write that lands in the very cycle an accumulation would carry out of the counter. The bench provokes this by loading the counter just below its wrap point with an active selector. It then issues a counter write, a selector write, or both, in the cycle that would otherwise wrap. A behavioural reference model is compared on every clock and judges the outcome: the written values must appear, and neither the flag nor the request may move.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int SEL_W  = 64;
  localparam int IDX_W  = 10;
  localparam int OP_W   = 5;
  localparam int NSLOT  = 4;

  localparam int OP0_LSB = 40;
  localparam int OP1_LSB = 45;
  localparam int OP2_LSB = 50;
  localparam int INH_LSB = 58;
  localparam int INH_W   = 5;
  localparam int OF_BIT  = 63;

  typedef enum logic [OP_W-1:0] {
    OP_OR  = 5'b00000,
    OP_AND = 5'b00001,
    OP_XOR = 5'b00010,
    OP_ADD = 5'b00100
  } op_e;

  localparam logic [2:0] PRIV_U  = 3'b000;
  localparam logic [2:0] PRIV_S  = 3'b001;
  localparam logic [2:0] PRIV_M  = 3'b011;
  localparam logic [2:0] PRIV_VU = 3'b100;
  localparam logic [2:0] PRIV_VS = 3'b101;

endpackage

// File: rtl/pmc_event_pick.sv
module pmc_event_pick #(
  parameter int NUM_EVENTS = 64,
  parameter int EV_W       = 6,
  parameter int IDX_W      = 10
) (
  input  logic [NUM_EVENTS*EV_W-1:0] ev_vec,
  input  logic [IDX_W-1:0]           idx,
  output logic [EV_W-1:0]            val
);

  // index 0 and indices beyond the populated range both yield zero
  always_comb begin
    val = '0;
    for (int k = 1; k <= NUM_EVENTS; k++) begin
      if (idx == IDX_W'(k)) val = ev_vec[(k-1)*EV_W +: EV_W];
    end
  end

endmodule

// File: rtl/pmc_combine.sv
module pmc_combine
  import pmc_pkg::*;
#(
  parameter int IN_W = 6
) (
  input  logic [OP_W-1:0] op,
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  output logic [IN_W:0]   y
);

  always_comb begin
    unique case (op)
      OP_AND:  y = {1'b0, a & b};
      OP_XOR:  y = {1'b0, a ^ b};
      OP_ADD:  y = {1'b0, a} + {1'b0, b};
      default: y = {1'b0, a | b};
    endcase
  end

endmodule

// File: rtl/pmc_mode_gate.sv
module pmc_mode_gate
  import pmc_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic [INH_W-1:0] inh,   // {M, S, U, VS, VU}
  output logic             blocked
);

  always_comb begin
    unique case (mode)
      PRIV_M:  blocked = inh[4];
      PRIV_S:  blocked = inh[3];
      PRIV_U:  blocked = inh[2];
      PRIV_VS: blocked = inh[1];
      PRIV_VU: blocked = inh[0];
      default: blocked = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmc_combo_counter.sv
module pmc_combo_counter
  import pmc_pkg::*;
#(
  parameter int NUM_EVENTS = 64,
  parameter int EV_W       = 6,
  parameter int CNT_W      = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EVENTS*EV_W-1:0] ev_inc,
  input  logic [2:0]                 priv_mode,
  input  logic                       count_inhibit,
  input  logic                       sel_wr_en,
  input  logic [SEL_W-1:0]           sel_wr_data,
  input  logic                       cnt_wr_en,
  input  logic [CNT_W-1:0]           cnt_wr_data,
  output logic [SEL_W-1:0]           sel_rd,
  output logic [CNT_W-1:0]           cnt_rd,
  output logic                       ovf_irq
);

  localparam int L1_W = EV_W + 1;
  localparam int L2_W = EV_W + 2;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             sel_en, cnt_en;

  logic [EV_W-1:0]  slot_val [NSLOT];
  logic [L1_W-1:0]  pair_res [2];
  logic [L2_W-1:0]  tree_res;
  logic             mode_blocked;
  logic             acc_en, wrap;
  logic [CNT_W:0]   sum;

  // four event pickers, one per selector slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_pick
    pmc_event_pick #(
      .NUM_EVENTS(NUM_EVENTS), .EV_W(EV_W), .IDX_W(IDX_W)
    ) i_pick (
      .ev_vec(ev_inc),
      .idx   (sel_q[g*IDX_W +: IDX_W]),
      .val   (slot_val[g])
    );
  end

  // first tree level: slots 0/1 and 2/3
  for (genvar p = 0; p < 2; p++) begin : g_pair
    pmc_combine #(.IN_W(EV_W)) i_pair (
      .op(sel_q[(p == 0 ? OP0_LSB : OP1_LSB) +: OP_W]),
      .a (slot_val[2*p]),
      .b (slot_val[2*p+1]),
      .y (pair_res[p])
    );
  end

  pmc_combine #(.IN_W(L1_W)) i_final (
    .op(sel_q[OP2_LSB +: OP_W]),
    .a (pair_res[0]),
    .b (pair_res[1]),
    .y (tree_res)
  );

  pmc_mode_gate i_gate (
    .mode   (priv_mode),
    .inh    (sel_q[INH_LSB +: INH_W]),
    .blocked(mode_blocked)
  );

  // next-state logic
  always_comb begin
    acc_en = !cnt_wr_en && !sel_wr_en && !count_inhibit && !mode_blocked;
    sum    = {1'b0, cnt_q} + {{(CNT_W + 1 - L2_W){1'b0}}, tree_res};
    wrap   = acc_en && sum[CNT_W];

    cnt_en = cnt_wr_en || acc_en;
    cnt_d  = cnt_wr_en ? cnt_wr_data : sum[CNT_W-1:0];

    sel_en = sel_wr_en || wrap;
    sel_d  = sel_q;
    if (sel_wr_en) sel_d = sel_wr_data;
    else           sel_d[OF_BIT] = 1'b1;

    irq_d  = wrap && !sel_q[OF_BIT];
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign sel_rd  = sel_q;
  assign cnt_rd  = cnt_q;
  assign ovf_irq = irq_q;

endmodule

// File: rtl/pmc_combo_counter_chk.sv
module pmc_combo_counter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_inhibit,
  input logic             sel_wr_en,
  input logic [63:0]      sel_wr_data,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic [63:0]      sel_rd,
  input logic [CNT_W-1:0] cnt_rd,
  input logic             ovf_irq
);

  a_r6_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count_inhibit && !cnt_wr_en) |=> $stable(cnt_rd));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);

  a_r7_irq_on_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (sel_rd[63] && !$past(sel_rd[63])));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd[63] && !sel_wr_en) |=> sel_rd[63]);

  a_r9_cnt_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt_rd == $past(cnt_wr_data)));

  a_r10_sel_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en |=> (sel_rd == $past(sel_wr_data) && !ovf_irq));

endmodule

bind pmc_combo_counter pmc_combo_counter_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_pmc_combo_counter.sv
module test_pmc_combo_counter;

  localparam int NEV = 64;
  localparam int EVW = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NEV*EVW-1:0] ev_inc;
  logic [2:0]       priv_mode;
  logic             count_inhibit;
  logic             sel_wr_en;
  logic [63:0]      sel_wr_data;
  logic             cnt_wr_en;
  logic [63:0]      cnt_wr_data;
  logic [63:0]      sel_rd;
  logic [63:0]      cnt_rd;
  logic             ovf_irq;

  pmc_combo_counter #(.NUM_EVENTS(NEV), .EV_W(EVW), .CNT_W(64)) i_pmc_combo_counter (
    .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .priv_mode(priv_mode),
    .count_inhibit(count_inhibit), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .sel_rd(sel_rd),
    .cnt_rd(cnt_rd), .ovf_irq(ovf_irq)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string tag = "R1";

  // stimulus requested by the scenario
  int          ev_vals [NEV];
  logic [2:0]  b_mode = 3'b011;
  bit          b_inh = 0;
  bit          b_swe = 0;
  logic [63:0] b_swd = '0;
  bit          b_cwe = 0;
  logic [63:0] b_cwd = '0;

  // reference model state
  logic [63:0] m_sel = '0;
  logic [63:0] m_cnt = '0;
  bit          m_irq = 0;

  function automatic int apply_op(int code, int a, int b);
    case (code)
      1: return a & b;
      2: return a ^ b;
      4: return a + b;
      default: return a | b;
    endcase
  endfunction

  function automatic int ev_of(int idx);
    if (idx == 0 || idx > NEV) return 0;
    return ev_vals[idx-1];
  endfunction

  function automatic bit mode_stopped(logic [2:0] m, logic [63:0] s);
    case (m)
      3'b011: return s[62];
      3'b001: return s[61];
      3'b000: return s[60];
      3'b101: return s[59];
      3'b100: return s[58];
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] mk_sel(int e0, int e1, int e2, int e3,
                                         int o0, int o1, int o2, logic [5:0] inh);
    logic [63:0] s = '0;
    s[9:0] = 10'(e0); s[19:10] = 10'(e1); s[29:20] = 10'(e2); s[39:30] = 10'(e3);
    s[44:40] = 5'(o0); s[49:45] = 5'(o1); s[54:50] = 5'(o2);
    s[63:58] = inh;
    return s;
  endfunction

  task automatic check64(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: compare, drive the requested inputs, advance the model
  task automatic cycle();
    int r0, r1, r2;
    bit acc, wr;
    logic [64:0] s;
    @(negedge clk);
    check64("cnt_rd", cnt_rd, m_cnt);
    check64("sel_rd", sel_rd, m_sel);
    check64("ovf_irq", {63'd0, ovf_irq}, {63'd0, m_irq});
    for (int k = 0; k < NEV; k++) ev_inc[k*EVW +: EVW] = EVW'(ev_vals[k]);
    priv_mode = b_mode; count_inhibit = b_inh;
    sel_wr_en = b_swe; sel_wr_data = b_swd;
    cnt_wr_en = b_cwe; cnt_wr_data = b_cwd;
    r0 = apply_op(int'(m_sel[44:40]), ev_of(int'(m_sel[9:0])), ev_of(int'(m_sel[19:10])));
    r1 = apply_op(int'(m_sel[49:45]), ev_of(int'(m_sel[29:20])), ev_of(int'(m_sel[39:30])));
    r2 = apply_op(int'(m_sel[54:50]), r0, r1);
    acc = !b_cwe && !b_swe && !b_inh && !mode_stopped(b_mode, m_sel);
    s = {1'b0, m_cnt} + 65'(r2);
    wr = acc && s[64];
    m_irq = wr && !m_sel[63];
    if (b_swe) m_sel = b_swd;
    else if (wr) m_sel[63] = 1'b1;
    if (b_cwe) m_cnt = b_cwd;
    else if (acc) m_cnt = s[63:0];
    b_swe = 0; b_cwe = 0;
  endtask

  task automatic wsel(logic [63:0] v); b_swe = 1; b_swd = v; cycle(); endtask
  task automatic wcnt(logic [63:0] v); b_cwe = 1; b_cwd = v; cycle(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at tag %s", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NEV; k++) ev_vals[k] = 0;
    rst_n = 1'b0; ev_inc = '0; priv_mode = 3'b011; count_inhibit = 0;
    sel_wr_en = 0; sel_wr_data = '0; cnt_wr_en = 0; cnt_wr_data = '0;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    check64("reset cnt", cnt_rd, '0);
    check64("reset sel", sel_rd, '0);
    check64("reset irq", {63'd0, ovf_irq}, '0);
    rst_n = 1'b1;
    tag = "R1"; repeat (2) cycle();

    // R2: slice mapping, index 0, last valid index, out-of-range index
    tag = "R2";
    for (int k = 0; k < NEV; k++) ev_vals[k] = (k * 7 + 3) % 64;
    wsel(mk_sel(1, 0, 0, 0, 4, 4, 4, 0)); repeat (3) cycle();
    wsel(mk_sel(NEV, 0, 0, 0, 4, 4, 4, 0)); repeat (3) cycle();
    wsel(mk_sel(0, 1023, NEV + 1, 0, 4, 4, 4, 0)); repeat (3) cycle();
    wsel(mk_sel(5, 17, 33, 50, 4, 4, 4, 0)); repeat (3) cycle();

    // R3: every operator code, including unlisted ones, in every stage
    tag = "R3";
    foreach (ev_vals[k]) ev_vals[k] = 0;
    ev_vals[0] = 6'b101101; ev_vals[1] = 6'b110011; ev_vals[2] = 6'b011110; ev_vals[3] = 6'b111000;
    for (int o = 0; o < 32; o += 1) begin
      wsel(mk_sel(1, 2, 3, 4, o, (o + 1) % 32, o ^ 4, 0)); cycle(); cycle();
    end

    // R4: widened ADD tree with maximal inputs
    tag = "R4";
    foreach (ev_vals[k]) ev_vals[k] = 63;
    wsel(mk_sel(1, 2, 3, 4, 4, 4, 4, 0)); repeat (4) cycle();
    wsel(mk_sel(1, 2, 3, 4, 4, 1, 4, 0)); repeat (2) cycle();
    wsel(mk_sel(7, 7, 9, 0, 4, 2, 4, 0)); repeat (2) cycle();

    // R5: each mode against each single inhibit bit
    tag = "R5";
    for (int b = 0; b < 5; b++) begin
      for (int m = 0; m < 8; m++) begin
        b_mode = 3'(m);
        wsel(mk_sel(1, 2, 0, 0, 4, 0, 0, 6'(1 << b)));
        cycle(); cycle();
      end
    end
    b_mode = 3'b011;

    // R6: global inhibit
    tag = "R6";
    wsel(mk_sel(1, 2, 3, 4, 4, 4, 4, 0));
    b_inh = 1; repeat (4) cycle();
    b_inh = 0; repeat (2) cycle();

    // R7: first wrap raises flag and a one-cycle request
    tag = "R7";
    foreach (ev_vals[k]) ev_vals[k] = 0;
    ev_vals[0] = 10;
    wsel(mk_sel(1, 0, 0, 0, 0, 0, 0, 0));
    wcnt(64'hFFFF_FFFF_FFFF_FFF9);
    repeat (4) cycle();

    // R8: flag stays through a second wrap, no new request; selector write clears
    tag = "R8";
    wcnt(64'hFFFF_FFFF_FFFF_FFFB);
    repeat (4) cycle();
    wsel(mk_sel(1, 0, 0, 0, 0, 0, 0, 0));
    wcnt(64'hFFFF_FFFF_FFFF_FFFE);
    repeat (3) cycle();

    // R9: counter write in the cycle that would wrap
    tag = "R9";
    wsel(mk_sel(1, 0, 0, 0, 0, 0, 0, 0));
    wcnt(64'hFFFF_FFFF_FFFF_FFFC);
    wcnt(64'h0000_0000_0000_1234);
    repeat (2) cycle();

    // R10: selector write, and both writes together, in a wrapping cycle
    tag = "R10";
    wcnt(64'hFFFF_FFFF_FFFF_FFFC);
    wsel(mk_sel(1, 0, 0, 0, 4, 0, 0, 0));
    repeat (2) cycle();
    wcnt(64'hFFFF_FFFF_FFFF_FFFD);
    b_cwe = 1; b_cwd = 64'hFFFF_FFFF_FFFF_FFF0;
    b_swe = 1; b_swd = mk_sel(1, 1, 0, 0, 4, 0, 0, 0);
    cycle();
    repeat (3) cycle();

    // R4: mixed random traffic against the model
    tag = "R4";
    for (int c = 0; c < 600; c++) begin
      foreach (ev_vals[k]) ev_vals[k] = int'($urandom_range(0, 63));
      b_mode = 3'($urandom_range(0, 7));
      b_inh  = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) begin
        b_swe = 1;
        b_swd = mk_sel(int'($urandom_range(0, 70)), int'($urandom_range(0, 70)),
                       int'($urandom_range(0, 70)), int'($urandom_range(0, 70)),
                       int'($urandom_range(0, 31)), int'($urandom_range(0, 4)),
                       4, 6'($urandom_range(0, 3)));
      end
      if ($urandom_range(0, 15) == 0) begin
        b_cwe = 1;
        b_cwd = ($urandom_range(0, 1) == 1) ? 64'hFFFF_FFFF_FFFF_FF80 + 64'($urandom_range(0, 127))
                                             : {$urandom, $urandom};
      end
      cycle();
    end
    cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule